// File: doc/BRIEF.md
# Half-Bridge Gate Drive Control Core

This block is the clocked decision logic for one leg of a half-bridge. It takes an active-high command for each switch, an active-low shutdown line, a flag from an overcurrent comparator and a digitised supply sample. From these it drives the enables of the high-side and low-side gates, plus the enable of an open-drain device that pulls the shared shutdown line low.

Every asynchronous input passes a two-flop synchroniser before use. A command that asks for both switches at once leaves both off. Any change in the requested switch first turns both gates off. A gate then turns on only after a programmable quiet interval, and that interval restarts if the request changes again before it ends. An overcurrent flag forces both gates off straight away, without waiting for the shutdown line to drop. It also pulls that line low and keeps it low until the line reads low. After that, the block stays off until the line reads high again.

Supply supervision compares the sample against two codes, so the lock on the gates has hysteresis. Thresholds and timing are parameters, given in ADC codes and clock cycles.

Top module: `hb_gate_ctrl`

## Requirements
- R1: After reset, hs_gate, ls_gate and sd_pull are 0, and both gates stay 0 while vcc_code has not yet reached VCC_ON_CODE, whatever the commands.
- R2: While sd_n reads 0, both gates are 0 whatever the commands; a fall of sd_n turns an on gate off at the third rising edge that samples it.
- R3: When hi_cmd and lo_cmd are both 1, both gates are 0; the off happens at the third edge.
- R4: With sd_n=1, supply good and no fault, hi_cmd alone turns on only hs_gate and lo_cmd alone turns on only ls_gate; from a settled idle state the gate rises at edge DEAD_CYC+4 after the command changes.
- R5: Any change of the requested side turns both gates off; a gate turns on only after both gates have been 0 for at least DEAD_CYC cycles, and a further change inside that window restarts the count.
- R6: hs_gate and ls_gate are never 1 in the same cycle.
- R7: oc_flag=1 forces both gates to 0 at the third edge that samples it, even while sd_n stays 1.
- R8: After an overcurrent, sd_pull rises together with the gates turning off. It stays 1 while sd_n reads 1 and falls at the third edge after sd_n is sampled 0.
- R9: Once sd_pull has fallen, the gates stay 0 until sd_n reads 1 again with oc_flag at 0; after that, normal control resumes.
- R10: The gates are released when vcc_code >= VCC_ON_CODE and locked when vcc_code <= VCC_OFF_CODE; between the two codes, the previous state holds. A lock turns the gates off at the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 1 | High-side command, active high |
| lo_cmd | input | 1 | Low-side command, active high |
| sd_n | input | 1 | Shared shutdown line level, 0 = shut down |
| oc_flag | input | 1 | Overcurrent comparator output, 1 = fault |
| vcc_code | input | VCC_W | Supply voltage sample, synchronous to clk |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| sd_pull | output | 1 | Open-drain pull-down enable for the shutdown line |

## Verification
The assertions are checked on every cycle. They cover the following: the gates are never on together; a gate turns on only after the quiet interval; fault, shutdown, interlock and undervoltage bring the gates off within their cycle bound; and the pull-down is held while the line is high and released only after the line was sampled low. Some behaviour can only be shown by the bench scenarios run against a cycle-accurate reference model. This includes the exact turn-on edge, the restart of the quiet interval after a second command change, the hysteresis band between the two supply codes, and the return to operation after the shutdown line rises again.

// File: rtl/hb_gate_pkg.sv
`timescale 1ns/1ps
package hb_gate_pkg;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_HI   = 2'd1,
    REQ_LO   = 2'd2
  } drv_req_e;

  typedef enum logic [1:0] {
    FLT_RUN   = 2'd0,
    FLT_PULL  = 2'd1,
    FLT_REARM = 2'd2
  } flt_state_e;
endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [DEPTH-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < DEPTH; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/hb_uvlo.sv
`timescale 1ns/1ps
module hb_uvlo #(
  parameter int VCC_W        = 10,
  parameter int VCC_ON_CODE  = 600,
  parameter int VCC_OFF_CODE = 525
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VCC_W-1:0] vcc_code,
  output logic             supply_ok
);
  localparam logic [VCC_W-1:0] ON_L  = VCC_W'(VCC_ON_CODE);
  localparam logic [VCC_W-1:0] OFF_L = VCC_W'(VCC_OFF_CODE);

  logic ok_q, ok_d, ok_en;

  always_comb begin
    ok_en = 1'b0;
    ok_d  = ok_q;
    if (!ok_q && (vcc_code >= ON_L)) begin
      ok_en = 1'b1;
      ok_d  = 1'b1;
    end else if (ok_q && (vcc_code <= OFF_L)) begin
      ok_en = 1'b1;
      ok_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0;
    end else if (ok_en) begin
      ok_q <= ok_d;
    end
  end

  assign supply_ok = ok_q;
endmodule

// File: rtl/hb_fault_fsm.sv
`timescale 1ns/1ps
module hb_fault_fsm
  import hb_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic oc_s,
  input  logic sd_s,
  output logic run,
  output logic pull
);
  flt_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      FLT_RUN:   if (oc_s) st_d = FLT_PULL;
      FLT_PULL:  if (!sd_s) st_d = FLT_REARM;
      FLT_REARM: begin
        if (oc_s)      st_d = FLT_PULL;
        else if (sd_s) st_d = FLT_RUN;
      end
      default:   st_d = FLT_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FLT_RUN;
    end else begin
      st_q <= st_d;
    end
  end

  assign run  = (st_q == FLT_RUN);
  assign pull = (st_q == FLT_PULL);
endmodule

// File: rtl/hb_deadtime.sv
`timescale 1ns/1ps
module hb_deadtime
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hi_s,
  input  logic lo_s,
  output logic hs,
  output logic ls
);
  localparam int            CW       = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(DEAD_CYC);

  drv_req_e      want, req_q, req_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hs_q, hs_d, ls_q, ls_d;

  always_comb begin
    want = REQ_NONE;
    if (en && hi_s && !lo_s)      want = REQ_HI;
    else if (en && lo_s && !hi_s) want = REQ_LO;
  end

  always_comb begin
    req_d = req_q;
    cnt_d = cnt_q;
    hs_d  = 1'b0;
    ls_d  = 1'b0;
    if (want != req_q) begin
      req_d = want;
      cnt_d = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      hs_d = (want == REQ_HI);
      ls_d = (want == REQ_LO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= REQ_NONE;
      cnt_q <= '0;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      cnt_q <= cnt_d;
      hs_q  <= hs_d;
      ls_q  <= ls_d;
    end
  end

  assign hs = hs_q;
  assign ls = ls_q;
endmodule

// File: rtl/hb_gate_ctrl.sv
`timescale 1ns/1ps
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int VCC_W        = 10,
  parameter int VCC_ON_CODE  = 600,
  parameter int VCC_OFF_CODE = 525,
  parameter int DEAD_CYC     = 45
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_cmd,
  input  logic             lo_cmd,
  input  logic             sd_n,
  input  logic             oc_flag,
  input  logic [VCC_W-1:0] vcc_code,
  output logic             hs_gate,
  output logic             ls_gate,
  output logic             sd_pull
);
  localparam int NSYNC = 4;

  logic [1:0]       rst_pipe;
  logic             rst_i;
  logic [NSYNC-1:0] raw_in, syn_in;
  logic             hi_s, lo_s, sd_s, oc_s;
  logic             supply_ok, run, drive_en;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_i = rst_pipe[1];

  assign raw_in = {hi_cmd, lo_cmd, sd_n, oc_flag};
  assign {hi_s, lo_s, sd_s, oc_s} = syn_in;

  hb_sync #(.WIDTH(NSYNC), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_i), .d(raw_in), .q(syn_in)
  );

  hb_uvlo #(.VCC_W(VCC_W), .VCC_ON_CODE(VCC_ON_CODE), .VCC_OFF_CODE(VCC_OFF_CODE)) u_uvlo (
    .clk(clk), .rst_n(rst_i), .vcc_code(vcc_code), .supply_ok(supply_ok)
  );

  hb_fault_fsm u_fault (
    .clk(clk), .rst_n(rst_i), .oc_s(oc_s), .sd_s(sd_s), .run(run), .pull(sd_pull)
  );

  // the fault flag gates the drive directly, bypassing the shutdown line
  assign drive_en = supply_ok & sd_s & run & ~oc_s;

  hb_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk(clk), .rst_n(rst_i), .en(drive_en), .hi_s(hi_s), .lo_s(lo_s),
    .hs(hs_gate), .ls(ls_gate)
  );
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
`timescale 1ns/1ps
module hb_gate_ctrl_chk #(
  parameter int VCC_W        = 10,
  parameter int VCC_OFF_CODE = 525,
  parameter int DEAD_CYC     = 45
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hi_cmd,
  input logic             lo_cmd,
  input logic             sd_n,
  input logic             oc_flag,
  input logic [VCC_W-1:0] vcc_code,
  input logic             hs_gate,
  input logic             ls_gate,
  input logic             sd_pull
);
  localparam int               LRW    = $clog2(DEAD_CYC + 2);
  localparam logic [LRW-1:0]   LR_MAX = LRW'(DEAD_CYC);
  localparam logic [VCC_W-1:0] OFF_L  = VCC_W'(VCC_OFF_CODE);

  logic [2:0]     oc_h, sdl_h, il_h;
  logic [1:0]     uv_h;
  logic [LRW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_h    <= '0;
      sdl_h   <= '0;
      il_h    <= '0;
      uv_h    <= '0;
      low_run <= '0;
    end else begin
      oc_h  <= {oc_h[1:0], oc_flag};
      sdl_h <= {sdl_h[1:0], ~sd_n};
      il_h  <= {il_h[1:0], hi_cmd & lo_cmd};
      uv_h  <= {uv_h[0], vcc_code <= OFF_L};
      if (hs_gate || ls_gate)   low_run <= '0;
      else if (low_run < LR_MAX) low_run <= low_run + 1'b1;
    end
  end

  AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (&sdl_h) |-> (!hs_gate && !ls_gate)); // R2
  AST_INTERLOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (&il_h) |-> (!hs_gate && !ls_gate)); // R3
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_gate) || $rose(ls_gate)) |-> (low_run >= LR_MAX)); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate)); // R6
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (&oc_h) |-> (!hs_gate && !ls_gate)); // R7
  AST_PULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_pull && !sdl_h[0]) |=> sd_pull); // R8
  AST_PULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_pull) |-> sdl_h[2]); // R8
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (&uv_h) |-> (!hs_gate && !ls_gate)); // R10
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(
  .VCC_W(VCC_W), .VCC_OFF_CODE(VCC_OFF_CODE), .DEAD_CYC(DEAD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .sd_n(sd_n),
  .oc_flag(oc_flag), .vcc_code(vcc_code), .hs_gate(hs_gate), .ls_gate(ls_gate),
  .sd_pull(sd_pull)
);

// File: tb/hb_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hb_gate_ctrl_bench;
  localparam int W    = 10;
  localparam int ON   = 600;
  localparam int OFF  = 525;
  localparam int D    = 45;
  localparam int LAG  = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hi_cmd = 1'b0, lo_cmd = 1'b0, oc_flag = 1'b0, ext_sd = 1'b1;
  logic         sd_n = 1'b1;
  logic [W-1:0] vcc_code = '0;
  logic         hs_gate, ls_gate, sd_pull;

  int    n_chk = 0, n_bad = 0;
  bit    cmp_on = 0, done = 0;
  string cur_req = "R1";
  int    pull_age = 0;

  // reference model state
  bit m_hi[$], m_lo[$], m_sd[$], m_oc[$];
  bit mr0, mr1, m_ok, m_hs, m_ls;
  int m_fst, m_prev, m_cnt;

  hb_gate_ctrl #(.VCC_W(W), .VCC_ON_CODE(ON), .VCC_OFF_CODE(OFF), .DEAD_CYC(D)) u_hb_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .sd_n(sd_n),
    .oc_flag(oc_flag), .vcc_code(vcc_code), .hs_gate(hs_gate), .ls_gate(ls_gate),
    .sd_pull(sd_pull)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic mdl_clear();
    m_hi = '{0, 0}; m_lo = '{0, 0}; m_sd = '{0, 0}; m_oc = '{0, 0};
    m_ok = 0; m_hs = 0; m_ls = 0; m_fst = 0; m_prev = 0; m_cnt = 0;
  endtask

  task automatic mdl_step(input bit line_v);
    bit en;
    int want;
    if (!rst_n) begin
      mr0 = 0; mr1 = 0;
      mdl_clear();
    end else begin
      if (!mr1) begin
        mdl_clear();
      end else begin
        en = m_ok && m_sd[0] && (m_fst == 0) && !m_oc[0];
        want = 0;
        if (en && m_hi[0] && !m_lo[0]) want = 1;
        else if (en && m_lo[0] && !m_hi[0]) want = 2;
        if (want != m_prev) begin
          m_prev = want; m_cnt = D; m_hs = 0; m_ls = 0;
        end else if (m_cnt > 0) begin
          m_cnt--; m_hs = 0; m_ls = 0;
        end else begin
          m_hs = (want == 1); m_ls = (want == 2);
        end
        case (m_fst)
          0: if (m_oc[0]) m_fst = 1;
          1: if (!m_sd[0]) m_fst = 2;
          default: if (m_oc[0]) m_fst = 1; else if (m_sd[0]) m_fst = 0;
        endcase
        if (!m_ok && int'(vcc_code) >= ON) m_ok = 1;
        else if (m_ok && int'(vcc_code) <= OFF) m_ok = 0;
        void'(m_hi.pop_front()); m_hi.push_back(hi_cmd);
        void'(m_lo.pop_front()); m_lo.push_back(lo_cmd);
        void'(m_sd.pop_front()); m_sd.push_back(line_v);
        void'(m_oc.pop_front()); m_oc.push_back(oc_flag);
      end
      mr1 = mr0; mr0 = 1;
    end
  endtask

  // line model, comparison and model step, all at the falling edge
  always @(negedge clk) begin
    bit line_v;
    if (sd_pull === 1'b1) pull_age++; else pull_age = 0;
    line_v = ext_sd && !(sd_pull === 1'b1 && pull_age >= LAG);
    sd_n = line_v;
    if (cmp_on && !done) begin
      chk(cur_req, "model hs_gate", hs_gate, m_hs);
      chk(cur_req, "model ls_gate", ls_gate, m_ls);
      chk(cur_req, "model sd_pull", sd_pull, m_fst == 1);
      chk("R6", "gates not both on", hs_gate & ls_gate, 1'b0);
    end
    mdl_step(line_v);
  end

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic after_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    mdl_clear(); mr0 = 0; mr1 = 0;
    repeat (2) @(posedge clk);
    cmp_on = 1;
    after_edges(2);
    chk("R1", "reset hs", hs_gate, 1'b0);
    chk("R1", "reset ls", ls_gate, 1'b0);
    chk("R1", "reset pull", sd_pull, 1'b0);
    adv(1); rst_n = 1'b1;
    hi_cmd = 1'b1;
    after_edges(80);
    chk("R1", "lockout before supply good", hs_gate, 1'b0);

    cur_req = "R10";
    adv(1); vcc_code = W'(ON - 1);
    after_edges(80);
    chk("R10", "below on code", hs_gate, 1'b0);
    adv(1); vcc_code = W'(ON);
    after_edges(D + 10);
    chk("R10", "released at on code", hs_gate, 1'b1);
    adv(1); vcc_code = W'(OFF + 1);
    after_edges(40);
    chk("R10", "held inside band", hs_gate, 1'b1);
    adv(1); vcc_code = W'(OFF);
    after_edges(1);
    chk("R10", "off code edge1", hs_gate, 1'b1);
    after_edges(1);
    chk("R10", "off code edge2", hs_gate, 1'b0);
    adv(1); vcc_code = W'(ON - 1);
    after_edges(D + 20);
    chk("R10", "stays locked inside band", hs_gate, 1'b0);
    adv(1); vcc_code = W'(ON); hi_cmd = 1'b0;
    after_edges(D + 20);

    cur_req = "R4";
    adv(1); hi_cmd = 1'b1;
    after_edges(3 + D);
    chk("R4", "hs before turn-on edge", hs_gate, 1'b0);
    after_edges(1);
    chk("R4", "hs at turn-on edge", hs_gate, 1'b1);
    chk("R4", "ls stays off", ls_gate, 1'b0);

    cur_req = "R5";
    adv(1); hi_cmd = 1'b0; lo_cmd = 1'b1;
    after_edges(2);
    chk("R5", "hs before off edge", hs_gate, 1'b1);
    after_edges(1);
    chk("R5", "hs off on change", hs_gate, 1'b0);
    after_edges(D);
    chk("R5", "ls held in dead time", ls_gate, 1'b0);
    after_edges(1);
    chk("R5", "ls after dead time", ls_gate, 1'b1);
    adv(1); lo_cmd = 1'b0; hi_cmd = 1'b1;
    adv(10); lo_cmd = 1'b1; hi_cmd = 1'b0;
    adv(10); lo_cmd = 1'b0; hi_cmd = 1'b1;
    after_edges(3 + D);
    chk("R5", "restarted window hs", hs_gate, 1'b0);
    after_edges(1);
    chk("R5", "hs after restarted window", hs_gate, 1'b1);

    cur_req = "R3";
    adv(1); lo_cmd = 1'b1;
    after_edges(2);
    chk("R3", "hs before interlock edge", hs_gate, 1'b1);
    after_edges(1);
    chk("R3", "interlock hs", hs_gate, 1'b0);
    after_edges(60);
    chk("R3", "interlock hs held", hs_gate, 1'b0);
    chk("R3", "interlock ls held", ls_gate, 1'b0);
    adv(1); lo_cmd = 1'b0;
    after_edges(D + 10);
    chk("R3", "recovery after interlock", hs_gate, 1'b1);

    cur_req = "R2";
    adv(1); ext_sd = 1'b0;
    after_edges(2);
    chk("R2", "hs before shutdown edge", hs_gate, 1'b1);
    after_edges(1);
    chk("R2", "shutdown hs", hs_gate, 1'b0);
    adv(1); hi_cmd = 1'b0; lo_cmd = 1'b1;
    after_edges(D + 20);
    chk("R2", "shutdown ls", ls_gate, 1'b0);
    chk("R2", "shutdown hs again", hs_gate, 1'b0);
    adv(1); ext_sd = 1'b1;
    after_edges(D + 20);
    chk("R4", "low side alone", ls_gate, 1'b1);
    chk("R4", "high side off", hs_gate, 1'b0);

    cur_req = "R7";
    adv(1); oc_flag = 1'b1;
    after_edges(2);
    chk("R7", "ls before fault edge", ls_gate, 1'b1);
    after_edges(1);
    chk("R7", "fault ls off", ls_gate, 1'b0);
    chk("R8", "pull on with fault", sd_pull, 1'b1);
    adv(1); oc_flag = 1'b0;
    cur_req = "R8";
    after_edges(10);
    chk("R8", "pull held while line high", sd_pull, 1'b1);
    for (int i = 0; i < 80 && sd_pull === 1'b1; i++) after_edges(1);
    chk("R8", "pull released after line low", sd_pull, 1'b0);
    cur_req = "R9";
    after_edges(D + 20);
    chk("R9", "resume after line high", ls_gate, 1'b1);

    adv(1); oc_flag = 1'b1; ext_sd = 1'b0;
    after_edges(3);
    chk("R9", "fault with line low ls", ls_gate, 1'b0);
    chk("R8", "pull asserted", sd_pull, 1'b1);
    after_edges(1);
    chk("R8", "pull quick release", sd_pull, 1'b0);
    adv(1); oc_flag = 1'b0;
    after_edges(40);
    chk("R9", "held off while line low", ls_gate, 1'b0);
    chk("R9", "pull stays released", sd_pull, 1'b0);
    adv(1); ext_sd = 1'b1;
    after_edges(D + 20);
    chk("R9", "resume after line rises", ls_gate, 1'b1);

    after_edges(4);
    finish_run();
  end
endmodule